// File: doc/BRIEF.md
# Slow Peripheral Clock Divider and Wait Generator

This block lets a fast processor share its bus with an I/O peripheral that cannot keep up with the processor clock. It runs from a base clock at twice the processor rate. From that base clock it makes the processor clock and a slower peripheral clock. The divide ratio is given in half steps, so ratios such as 2.5 need no second oscillator.

When the processor starts an I/O cycle whose low address bits match a fixed base, the block selects the peripheral. It also holds the processor's active-low wait line for a number of processor cycles derived from the ratio. Memory cycles, interrupt-acknowledge cycles and I/O cycles to other addresses run with no added wait states. Within one I/O cycle the wait is applied once only. It is armed again only after the I/O request has gone inactive.

The ratio input `halfRatio` holds N, meaning that the peripheral clock is the base clock divided by N. The processor-side ratio is therefore N/2. The wait count is N/2 rounded up.

Top module: `slow_io_wait`

## Requirements
- R1: `cpuClk` is the base clock divided by 2. It is low during reset and toggles on every rising edge of `clk` afterwards.
- R2: `perClk` repeats every N cycles of `clk`, where N is `halfRatio`. Any value of `halfRatio` below 4 is treated as 4.
- R3: Each period of `perClk` is high for floor(N/2) cycles of `clk` and low for the rest. The output is driven from a register.
- R4: `perSelN` is low exactly when `iorqN` is 0, `m1N` is 1 and `(addr & ADDR_MASK) == (BASE_ADDR & ADDR_MASK)`. The default parameters select addresses 0x40 to 0x4F.
- R5: For a selected I/O cycle, `waitN` goes low in the first processor cycle of the access. It stays low for exactly ceil(N/2) processor cycles, counted at the rising edges of `cpuClk`. Integer ratios 2, 3, 4 and 8 therefore give 2, 3, 4 and 8 waits.
- R6: Memory cycles (`iorqN` 1), interrupt-acknowledge cycles (`m1N` 0) and I/O cycles to a non-matching address leave `waitN` high throughout.
- R7: Once the waits of an access have run out, `waitN` stays high for as long as `iorqN` stays low, even if `addr` moves to another matching address. The next access after `iorqN` has been high at a rising edge of `cpuClk` gets the full wait count again.
- R8: While `rstN` is 0, `waitN` is high even when an access is selected. Reset also clears the wait counter and sets the divider phase and `perClk` to zero.
- R9: The fractional setting N = 5 (ratio 2.5) gives a `perClk` period of 5 base cycles and 3 wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock at twice the processor rate |
| rstN | input | 1 | Synchronous reset, active low |
| iorqN | input | 1 | Processor I/O request, active low |
| m1N | input | 1 | Processor opcode-fetch / acknowledge marker, active low |
| addr | input | ADDR_W | Low processor address bits |
| halfRatio | input | RATIO_W | Peripheral divide ratio N, in base-clock cycles |
| cpuClk | output | 1 | Processor clock, base / 2 |
| perClk | output | 1 | Divided peripheral clock, base / N |
| perSelN | output | 1 | Peripheral select, active low |
| waitN | output | 1 | Processor wait request, active low |

## Verification
Select and the first wait cycle follow the bus inputs combinationally. The bench drives the inputs one time unit after a rising edge of `cpuClk` and reads them at the next falling edge of `clk`, still inside that same processor cycle. The wait counter moves only at rising edges of `cpuClk`. Each later wait cycle is therefore sampled once per processor cycle, at the falling edge of `clk` that follows the edge that updated the counter. `perClk` sits one register behind its phase counter, so its period and high time are measured by counting falling edges of `clk` between transitions. The bench does not predict an absolute phase for `perClk`.

// File: rtl/slow_io_pkg.sv
package slow_io_pkg;

  // Strobes from the select/arming control into the counting datapath.
  // Each is valid for one base clock and only on a processor tick.
  typedef struct packed {
    logic load;   // start a wait run
    logic dec;    // count one processor cycle of wait
    logic clear;  // drop any run, bus has released the I/O request
  } waitStrobe_t;

endpackage

// File: rtl/slow_io_ctrl.sv
module slow_io_ctrl
  import slow_io_pkg::*;
#(
  parameter int                 ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 'h40,
  parameter logic [ADDR_W-1:0]  ADDR_MASK = 'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              iorqN,
  input  logic              m1N,
  input  logic [ADDR_W-1:0] addr,
  input  logic              tick,
  input  logic              cntNz,
  output waitStrobe_t       strobe,
  output logic              selN,
  output logic              waitN
);

  localparam logic [ADDR_W-1:0] MATCH = BASE_ADDR & ADDR_MASK;

  logic sel;
  logic armed;

  // Plain I/O cycle to the slow device: not an acknowledge, address hit.
  assign sel  = !iorqN && m1N && ((addr & ADDR_MASK) == MATCH);
  assign selN = !sel;

  always_comb begin
    strobe       = '0;
    strobe.clear = tick && iorqN;
    strobe.load  = tick && sel && armed;
    strobe.dec   = tick && !strobe.load && !strobe.clear && cntNz;
  end

  // One wait run per I/O request; rearmed once the request goes away.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b1;
    end else if (tick) begin
      if (iorqN)            armed <= 1'b1;
      else if (strobe.load) armed <= 1'b0;
    end
  end

  // First T-state is covered by 'armed' before the counter is loaded.
  assign waitN = !(rstN && sel && (armed || cntNz));

endmodule

// File: rtl/slow_io_dp.sv
module slow_io_dp
  import slow_io_pkg::*;
#(
  parameter int RATIO_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] halfRatio,
  input  waitStrobe_t        strobe,
  output logic               tick,
  output logic               cntNz,
  output logic               cpuClk,
  output logic               perClk
);

  localparam logic [RATIO_W-1:0] MIN_HALF = RATIO_W'(4);

  logic [RATIO_W-1:0] effHalf;
  logic [RATIO_W:0]   halfUp;
  logic [RATIO_W-1:0] waitLoad;
  logic [RATIO_W-1:0] hiLen;
  logic [RATIO_W-1:0] divCnt;
  logic [RATIO_W-1:0] divNext;
  logic [RATIO_W-1:0] waitCnt;
  logic               cpuClkQ;
  logic               perClkQ;

  // Ratio decode: clamp, wait count = ceil(N/2) processor cycles.
  assign effHalf  = (halfRatio < MIN_HALF) ? MIN_HALF : halfRatio;
  assign halfUp   = ({1'b0, effHalf} + 1'b1) >> 1;
  assign waitLoad = halfUp[RATIO_W-1:0] - 1'b1;
  assign hiLen    = effHalf >> 1;

  // Processor clock: base / 2; a tick is the edge where it rises.
  always_ff @(posedge clk) begin
    if (!rstN) cpuClkQ <= 1'b0;
    else       cpuClkQ <= !cpuClkQ;
  end
  assign tick   = !cpuClkQ;
  assign cpuClk = cpuClkQ;

  // Peripheral divider; '>=' keeps it bounded if the ratio shrinks live.
  assign divNext = (divCnt >= effHalf - 1'b1) ? '0 : divCnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      perClkQ <= 1'b0;
    end else begin
      divCnt  <= divNext;
      perClkQ <= (divNext < hiLen);
    end
  end
  assign perClk = perClkQ;

  // Wait down-counter in processor cycles.
  always_ff @(posedge clk) begin
    if (!rstN)             waitCnt <= '0;
    else if (strobe.clear) waitCnt <= '0;
    else if (strobe.load)  waitCnt <= waitLoad;
    else if (strobe.dec)   waitCnt <= waitCnt - 1'b1;
  end
  assign cntNz = (waitCnt != '0);

endmodule

// File: rtl/slow_io_wait.sv
module slow_io_wait
  import slow_io_pkg::*;
#(
  parameter int                 ADDR_W    = 8,
  parameter int                 RATIO_W   = 5,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 'h40,
  parameter logic [ADDR_W-1:0]  ADDR_MASK = 'hF0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               iorqN,
  input  logic               m1N,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [RATIO_W-1:0] halfRatio,
  output logic               cpuClk,
  output logic               perClk,
  output logic               perSelN,
  output logic               waitN
);

  waitStrobe_t strobe;
  logic        tick;
  logic        cntNz;

  slow_io_ctrl #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .ADDR_MASK(ADDR_MASK)
  ) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .iorqN (iorqN),
    .m1N   (m1N),
    .addr  (addr),
    .tick  (tick),
    .cntNz (cntNz),
    .strobe(strobe),
    .selN  (perSelN),
    .waitN (waitN)
  );

  slow_io_dp #(
    .RATIO_W(RATIO_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .halfRatio(halfRatio),
    .strobe   (strobe),
    .tick     (tick),
    .cntNz    (cntNz),
    .cpuClk   (cpuClk),
    .perClk   (perClk)
  );

endmodule

// File: rtl/slow_io_wait_chk.sv
module slow_io_wait_chk #(
  parameter int                 ADDR_W    = 8,
  parameter int                 RATIO_W   = 5,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 'h40,
  parameter logic [ADDR_W-1:0]  ADDR_MASK = 'hF0
) (
  input logic              clk,
  input logic              rstN,
  input logic              iorqN,
  input logic              m1N,
  input logic [ADDR_W-1:0] addr,
  input logic              cpuClk,
  input logic              perSelN,
  input logic              waitN
);

  localparam int MAX_WAIT = (2 ** RATIO_W) / 2;

  logic [RATIO_W:0] runCnt;

  // Consecutive processor ticks with the wait line low.
  always_ff @(posedge clk) begin
    if (!rstN)                          runCnt <= '0;
    else if (!cpuClk) begin
      if (waitN)                        runCnt <= '0;
      else if (runCnt != '1)            runCnt <= runCnt + 1'b1;
    end
  end

  a_r1_cpu_clk_toggles: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cpuClk != $past(cpuClk)));

  a_r4_sel_addr_hit: assert property (@(posedge clk) disable iff (!rstN)
    !perSelN |-> ((addr & ADDR_MASK) == (BASE_ADDR & ADDR_MASK)));

  a_r6_wait_only_io: assert property (@(posedge clk) disable iff (!rstN)
    !waitN |-> (!iorqN && m1N && !perSelN));

  a_r5_wait_bounded: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= (RATIO_W+1)'(MAX_WAIT));

  // R8: wait line released while reset is held
  always @(posedge clk) begin
    if (!rstN) a_r8_reset_no_wait: assert (waitN);
  end

endmodule

bind slow_io_wait slow_io_wait_chk #(
  .ADDR_W   (ADDR_W),
  .RATIO_W  (RATIO_W),
  .BASE_ADDR(BASE_ADDR),
  .ADDR_MASK(ADDR_MASK)
) i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .iorqN  (iorqN),
  .m1N    (m1N),
  .addr   (addr),
  .cpuClk (cpuClk),
  .perSelN(perSelN),
  .waitN  (waitN)
);

// File: tb/test_slow_io_wait.sv
module test_slow_io_wait;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {halfRatio, expected period, expected high time, expected waits}
  localparam int VEC [0:NVEC-1][0:3] = '{
    '{4, 4, 2, 2}, '{5, 5, 2, 3}, '{6, 6, 3, 3}, '{8, 8, 4, 4},
    '{16, 16, 8, 8}, '{3, 4, 2, 2}, '{7, 7, 3, 4}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       iorqN = 1'b1;
  logic       m1N = 1'b1;
  logic [7:0] addr = 8'h00;
  logic [4:0] halfRatio = 5'd4;
  logic       cpuClk, perClk, perSelN, waitN;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slow_io_wait i_slow_io_wait (
    .clk(clk), .rstN(rstN), .iorqN(iorqN), .m1N(m1N), .addr(addr),
    .halfRatio(halfRatio), .cpuClk(cpuClk), .perClk(perClk),
    .perSelN(perSelN), .waitN(waitN)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // One bus cycle held for 'hold' processor cycles; counts low samples.
  task automatic busCycle(input bit io, input bit m1, input logic [7:0] a,
                          input int hold, output int waits, output int sels);
    @(posedge cpuClk); #1;
    iorqN = !io; m1N = m1; addr = a;
    waits = 0; sels = 0;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!waitN)   waits++;
      if (!perSelN) sels++;
      @(posedge cpuClk); #1;
    end
    iorqN = 1'b1; m1N = 1'b1;
  endtask

  task automatic measurePer(output int hi, output int lo);
    @(negedge clk);
    while (perClk !== 1'b0) @(negedge clk);
    while (perClk !== 1'b1) @(negedge clk);
    hi = 0;
    while (perClk === 1'b1) begin hi++; @(negedge clk); end
    lo = 0;
    while (perClk === 1'b0) begin lo++; @(negedge clk); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int w, s, hi, lo, c0;
    // R8: reset with a selected access on the bus
    repeat (2) @(negedge clk);
    iorqN = 1'b0; addr = 8'h42;
    repeat (2) @(negedge clk);
    chk("R8 waitN in reset", int'(waitN), 1);
    chk("R8 perClk in reset", int'(perClk), 0);
    chk("R1 cpuClk in reset", int'(cpuClk), 0);
    iorqN = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    // R1: toggles each base cycle
    @(negedge clk); c0 = int'(cpuClk);
    @(negedge clk);
    chk("R1 cpuClk toggle", int'(cpuClk), 1 - c0);

    // Table walk: R2 period, R3 high time, R5/R9 waits, R4 select
    for (int v = 0; v < NVEC; v++) begin
      halfRatio = 5'(VEC[v][0]);
      doReset();
      measurePer(hi, lo);
      chk(VEC[v][0] == 5 ? "R9 period" : "R2 period", hi + lo, VEC[v][1]);
      chk("R3 high time", hi, VEC[v][2]);
      busCycle(1'b1, 1'b1, 8'h40 + 8'(v), VEC[v][3] + 4, w, s);
      chk(VEC[v][0] == 5 ? "R9 waits" : "R5 waits", w, VEC[v][3]);
      chk("R4 select cycles", s, VEC[v][3] + 4);
    end

    // R6: cycles that must run at full speed
    halfRatio = 5'd8;
    doReset();
    busCycle(1'b0, 1'b1, 8'h40, 10, w, s);
    chk("R6 memory cycle waits", w, 0);
    chk("R4 memory cycle select", s, 0);
    busCycle(1'b1, 1'b0, 8'h41, 10, w, s);
    chk("R6 acknowledge waits", w, 0);
    chk("R4 acknowledge select", s, 0);
    busCycle(1'b1, 1'b1, 8'h80, 10, w, s);
    chk("R6 other address waits", w, 0);
    chk("R4 other address select", s, 0);

    // R7: no second run without releasing the request
    @(posedge cpuClk); #1;
    iorqN = 1'b0; m1N = 1'b1; addr = 8'h41;
    w = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); if (!waitN) w++;
      @(posedge cpuClk); #1;
    end
    chk("R7 first run waits", w, 4);
    addr = 8'h47;
    w = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); if (!waitN) w++;
      @(posedge cpuClk); #1;
    end
    chk("R7 held request waits", w, 0);
    iorqN = 1'b1;
    busCycle(1'b1, 1'b1, 8'h4F, 8, w, s);
    chk("R7 rearmed waits", w, 4);

    // R5 first T-state, then R8 reset mid-run
    halfRatio = 5'd16;
    @(posedge cpuClk); #1;
    iorqN = 1'b0; addr = 8'h40;
    @(negedge clk);
    chk("R5 wait in first cycle", int'(waitN), 0);
    rstN = 1'b0;
    #1;
    chk("R8 wait dropped by reset", int'(waitN), 1);
    repeat (2) @(negedge clk);
    iorqN = 1'b1;
    rstN = 1'b1;
    busCycle(1'b1, 1'b1, 8'h40, 12, w, s);
    chk("R8 counter cleared, full run", w, 8);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule